// File: doc/BRIEF.md
# Physical Register Wakeup Scoreboard

This block tracks, for each physical register, whether its value has been produced, and which in-flight consumers are still waiting on it. When a producing operation is dispatched, its destination register is marked not ready. When a consumer is dispatched, each of its source operands is either counted ready at once or recorded as a waiter on that register. When a producer completes, every waiter on its destination has that operand marked ready and is dropped from the register's list. Any consumer whose last pending operand was just satisfied is reported on a per-slot wakeup vector.

Consumers are named by a slot tag, which indexes a fixed set of queue slots owned by the surrounding issue logic. For each register, the set of waiting slots is kept as a bit vector over slot tags, so a squashed consumer is removed by clearing one column. Register indices at or above the tracked register count stand for registers that are not renamed. These are never tracked and always count as ready. Picking which woken consumer to issue is left to the surrounding issue logic, and so is storing the queue entries.

Top module: `preg_wakeup_sb`

## Requirements
- R1: After reset every tracked register reads ready on `reg_ready` and `wake_vec` is all zero.
- R2: A dispatch with a valid destination index below NUM_PREGS clears that register's `reg_ready` bit from the cycle after the dispatch edge.
- R3: A destination index at or above NUM_PREGS leaves `reg_ready` unchanged. A source index at or above NUM_PREGS, or a source whose valid flag is low, counts as ready.
- R4: A consumer whose sources are all ready at dispatch raises `wake_vec[tag]` for exactly the one cycle after the dispatch edge.
- R5: A completion on a tracked register sets its `reg_ready` bit. Each consumer whose last pending source was that register raises its `wake_vec` bit in the cycle after the completion edge. A consumer that still has another pending source stays silent.
- R6: A consumer whose two sources name the same pending register is woken by a single completion of that register.
- R7: A completion presented in the same cycle as a dispatch counts as already ready for that dispatch's sources.
- R8: A squash with `sqsh_exempt` low removes the slot from every waiting list. A later completion of a register it waited on does not raise its `wake_vec` bit.
- R9: A squash with `sqsh_exempt` high has no effect: the consumer stays waiting and is woken by the later completion.
- R10: A tracked destination must not be dispatched while any consumer still waits on that register, unless that register completes in the same cycle.
- R11: One completion can wake several slots in the same cycle, each on its own `wake_vec` bit (bit n belongs to slot tag n).
- R12: When a dispatch destination and a completion name the same register in one cycle, the register ends not ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch strobe |
| disp_tag | input | TAG_W | Slot tag of the dispatched operation |
| disp_dst_vld | input | 1 | Dispatched operation writes a register |
| disp_dst | input | REG_W | Destination register index |
| disp_s0_vld | input | 1 | First source is used |
| disp_s0 | input | REG_W | First source register index |
| disp_s1_vld | input | 1 | Second source is used |
| disp_s1 | input | REG_W | Second source register index |
| cmpl_valid | input | 1 | Completion strobe |
| cmpl_reg | input | REG_W | Register produced by the completing operation |
| sqsh_valid | input | 1 | Squash-remove strobe |
| sqsh_tag | input | TAG_W | Slot tag to remove |
| sqsh_exempt | input | 1 | Slot holds a store or non-speculative op; removal is skipped |
| wake_vec | output | NUM_SLOTS | One-cycle pulse per slot that became ready |
| reg_ready | output | NUM_PREGS | Ready bit of each tracked register |

## Verification
A stale waiting-list bit, or a pending flag that was never cleared, shows at the ports as a wake pulse that is missing or extra. It appears in the cycle right after the completion that should or should not have caused it. A ready bit set or cleared wrongly shows on `reg_ready` one cycle after the dispatch or completion. It also shows later, when a consumer dispatched against that register wakes at once instead of waiting, or the other way round. Because every wake pulse lasts exactly one cycle, comparing both output vectors against a reference model on every cycle catches each such error on the first cycle it can be seen.

// File: rtl/pwsb_pkg.sv
package pwsb_pkg;
   // Registers at or above the tracked count are not renamed and never tracked
   function automatic logic idx_tracked(input int unsigned idx, input int unsigned limit);
      return idx < limit;
   endfunction
endpackage

// File: rtl/pwsb_ready_bits.sv
module pwsb_ready_bits #(
   parameter int NUM_PREGS = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PREGS-1:0] set_vec,
   input  logic [NUM_PREGS-1:0] clr_vec,
   output logic [NUM_PREGS-1:0] rdy
);
   // Completion sets first, then a same-cycle producer dispatch clears again
   always_ff @(posedge clk) begin
      if (!rst_n) rdy <= '1;
      else        rdy <= (rdy | set_vec) & ~clr_vec;
   end

   p_dispatch_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_vec) |=> ((rdy & $past(clr_vec)) == '0));

   p_complete_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_vec & ~clr_vec)) |=> ((rdy & $past(set_vec & ~clr_vec)) == $past(set_vec & ~clr_vec)));
endmodule

// File: rtl/pwsb_wait_matrix.sv
module pwsb_wait_matrix #(
   parameter int NUM_PREGS = 24,
   parameter int NUM_SLOTS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PREGS-1:0] add_row,
   input  logic [NUM_SLOTS-1:0] add_col,
   input  logic [NUM_PREGS-1:0] clr_row,
   input  logic [NUM_SLOTS-1:0] clr_col,
   output logic [NUM_SLOTS-1:0] woken,
   output logic [NUM_PREGS-1:0] row_busy
);
   logic [NUM_SLOTS-1:0] wl [NUM_PREGS];
   logic [NUM_SLOTS-1:0] hit_rows [NUM_PREGS+1];
   logic [NUM_PREGS-1:0] col_bits [NUM_SLOTS];

   assign hit_rows[0] = '0;

   for (genvar r = 0; r < NUM_PREGS; r++) begin : g_row
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wl[r] <= '0;
         end else begin
            wl[r] <= (clr_row[r] ? '0 : (wl[r] & ~clr_col)) | (add_row[r] ? add_col : '0);
         end
      end
      assign hit_rows[r+1] = hit_rows[r] | (clr_row[r] ? wl[r] : '0);
      assign row_busy[r]   = |wl[r];
      for (genvar c = 0; c < NUM_SLOTS; c++) begin : g_cell
         assign col_bits[c][r] = wl[r][c];
      end

      // The producer's list is drained in full by its completion
      p_row_drained_r5: assert property (@(posedge clk) disable iff (!rst_n)
         clr_row[r] |=> (wl[r] == '0));
   end

   assign woken = hit_rows[NUM_PREGS];

   for (genvar c = 0; c < NUM_SLOTS; c++) begin : g_col
      p_squash_removes_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_col[c] && !add_col[c]) |=> (col_bits[c] == '0));
   end
endmodule

// File: rtl/pwsb_slot_array.sv
module pwsb_slot_array #(
   parameter int NUM_SLOTS = 8,
   parameter int REG_W     = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] disp_hit,
   input  logic                 pend0_in,
   input  logic                 pend1_in,
   input  logic [REG_W-1:0]     src0_in,
   input  logic [REG_W-1:0]     src1_in,
   input  logic [NUM_SLOTS-1:0] sq_hit,
   input  logic [NUM_SLOTS-1:0] woken,
   input  logic [REG_W-1:0]     cmpl_reg,
   output logic [NUM_SLOTS-1:0] wake_vec
);
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic             p0_q, p1_q;
      logic [REG_W-1:0] s0_q, s1_q;
      logic             np0, np1;

      assign np0 = p0_q && (s0_q != cmpl_reg);
      assign np1 = p1_q && (s1_q != cmpl_reg);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            p0_q        <= 1'b0;
            p1_q        <= 1'b0;
            s0_q        <= '0;
            s1_q        <= '0;
            wake_vec[s] <= 1'b0;
         end else if (disp_hit[s]) begin
            p0_q        <= pend0_in;
            p1_q        <= pend1_in;
            s0_q        <= src0_in;
            s1_q        <= src1_in;
            wake_vec[s] <= !pend0_in && !pend1_in;
         end else if (sq_hit[s]) begin
            p0_q        <= 1'b0;
            p1_q        <= 1'b0;
            wake_vec[s] <= 1'b0;
         end else if (woken[s]) begin
            p0_q        <= np0;
            p1_q        <= np1;
            wake_vec[s] <= (p0_q || p1_q) && !(np0 || np1);
         end else begin
            wake_vec[s] <= 1'b0;
         end
      end

      p_wake_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
         wake_vec[s] |-> (!p0_q && !p1_q));

      p_squash_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (sq_hit[s] && !disp_hit[s]) |=> !wake_vec[s]);
   end
endmodule

// File: rtl/preg_wakeup_sb.sv
module preg_wakeup_sb #(
   parameter int NUM_PREGS = 24,
   parameter int REG_W     = 5,
   parameter int NUM_SLOTS = 8,
   localparam int TAG_W    = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 disp_valid,
   input  logic [TAG_W-1:0]     disp_tag,
   input  logic                 disp_dst_vld,
   input  logic [REG_W-1:0]     disp_dst,
   input  logic                 disp_s0_vld,
   input  logic [REG_W-1:0]     disp_s0,
   input  logic                 disp_s1_vld,
   input  logic [REG_W-1:0]     disp_s1,
   input  logic                 cmpl_valid,
   input  logic [REG_W-1:0]     cmpl_reg,
   input  logic                 sqsh_valid,
   input  logic [TAG_W-1:0]     sqsh_tag,
   input  logic                 sqsh_exempt,
   output logic [NUM_SLOTS-1:0] wake_vec,
   output logic [NUM_PREGS-1:0] reg_ready
);
   import pwsb_pkg::*;

   if (NUM_PREGS < 1 || NUM_PREGS > (1 << REG_W)) begin : g_bad_pregs
      $error("NUM_PREGS must lie in 1 .. 2**REG_W");
   end
   if (NUM_SLOTS < 2) begin : g_bad_slots
      $error("NUM_SLOTS must be at least 2");
   end

   logic [NUM_PREGS-1:0] dst_oh, s0_oh, s1_oh, cm_oh;
   logic [NUM_SLOTS-1:0] dtag_oh, stag_oh;

   for (genvar r = 0; r < NUM_PREGS; r++) begin : g_rdec
      assign dst_oh[r] = (disp_dst == REG_W'(r));
      assign s0_oh[r]  = (disp_s0  == REG_W'(r));
      assign s1_oh[r]  = (disp_s1  == REG_W'(r));
      assign cm_oh[r]  = (cmpl_reg == REG_W'(r));
   end
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_tdec
      assign dtag_oh[s] = disp_valid && (disp_tag == TAG_W'(s));
      assign stag_oh[s] = sqsh_valid && !sqsh_exempt && (sqsh_tag == TAG_W'(s));
   end

   logic dst_trk, cm_trk, s0_pend, s1_pend;
   logic [NUM_PREGS-1:0] set_vec, clr_vec, add_row, row_busy;
   logic [NUM_SLOTS-1:0] woken;

   assign dst_trk = disp_valid && disp_dst_vld && idx_tracked(int'(disp_dst), NUM_PREGS);
   assign cm_trk  = cmpl_valid && idx_tracked(int'(cmpl_reg), NUM_PREGS);

   // Untracked indices never hit the decoded vectors; same-cycle completion forwards
   assign s0_pend = disp_valid && disp_s0_vld && (|(s0_oh & ~reg_ready & ~(cm_trk ? cm_oh : '0)));
   assign s1_pend = disp_valid && disp_s1_vld && (|(s1_oh & ~reg_ready & ~(cm_trk ? cm_oh : '0)));

   assign set_vec = cm_trk  ? cm_oh  : '0;
   assign clr_vec = dst_trk ? dst_oh : '0;
   assign add_row = (s0_pend ? s0_oh : '0) | (s1_pend ? s1_oh : '0);

   pwsb_ready_bits #(.NUM_PREGS(NUM_PREGS)) i_ready (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .rdy(reg_ready)
   );

   pwsb_wait_matrix #(.NUM_PREGS(NUM_PREGS), .NUM_SLOTS(NUM_SLOTS)) i_wait (
      .clk(clk), .rst_n(rst_n), .add_row(add_row), .add_col(dtag_oh),
      .clr_row(set_vec), .clr_col(stag_oh | dtag_oh), .woken(woken), .row_busy(row_busy)
   );

   pwsb_slot_array #(.NUM_SLOTS(NUM_SLOTS), .REG_W(REG_W)) i_slots (
      .clk(clk), .rst_n(rst_n), .disp_hit(dtag_oh), .pend0_in(s0_pend), .pend1_in(s1_pend),
      .src0_in(disp_s0), .src1_in(disp_s1), .sq_hit(stag_oh), .woken(woken),
      .cmpl_reg(cmpl_reg), .wake_vec(wake_vec)
   );

   // A new producer may not be recorded while consumers still wait on the register
   p_single_producer_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dst_trk |-> ((row_busy & dst_oh & ~set_vec) == '0));
endmodule

// File: tb/test_preg_wakeup_sb.sv
`timescale 1ns/1ps
module test_preg_wakeup_sb;
   localparam int NP = 24, RW = 5, NS = 8, TW = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic dv = 0, dstv = 0, s0v = 0, s1v = 0, cv = 0, sv = 0, sx = 0;
   logic [TW-1:0] dt = '0, st = '0;
   logic [RW-1:0] dst = '0, s0 = '0, s1 = '0, cr = '0;
   logic [NS-1:0] wake_vec;
   logic [NP-1:0] reg_ready;

   always #10 clk = ~clk;

   preg_wakeup_sb #(.NUM_PREGS(NP), .REG_W(RW), .NUM_SLOTS(NS)) i_preg_wakeup_sb (
      .clk(clk), .rst_n(rst_n), .disp_valid(dv), .disp_tag(dt), .disp_dst_vld(dstv),
      .disp_dst(dst), .disp_s0_vld(s0v), .disp_s0(s0), .disp_s1_vld(s1v), .disp_s1(s1),
      .cmpl_valid(cv), .cmpl_reg(cr), .sqsh_valid(sv), .sqsh_tag(st), .sqsh_exempt(sx),
      .wake_vec(wake_vec), .reg_ready(reg_ready)
   );

   int checks = 0, fails = 0;
   bit done = 0;
   bit m_rdy[NP];
   bit m_p0[NS], m_p1[NS], m_busy[NS];
   int m_s0[NS], m_s1[NS];
   logic [NS-1:0] exp_wake;

   function automatic logic [NP-1:0] rdy_vec();
      logic [NP-1:0] v;
      for (int i = 0; i < NP; i++) v[i] = m_rdy[i];
      return v;
   endfunction

   function automatic bit src_pending(bit vld, int idx, bit ctrk, int creg);
      return vld && idx < NP && !m_rdy[idx] && !(ctrk && creg == idx);
   endfunction

   function automatic bit waits_on(int r);
      for (int s = 0; s < NS; s++)
         if ((m_p0[s] && m_s0[s] == r) || (m_p1[s] && m_s1[s] == r)) return 1;
      return 0;
   endfunction

   task automatic model_step();
      bit ctrk, pa, pb, had;
      ctrk = cv && int'(cr) < NP;
      exp_wake = '0;
      pa = dv && src_pending(s0v, int'(s0), ctrk, int'(cr));
      pb = dv && src_pending(s1v, int'(s1), ctrk, int'(cr));
      if (sv && !sx && !(dv && dt == st)) begin
         m_p0[st] = 0; m_p1[st] = 0; m_busy[st] = 0;
      end
      if (ctrk)
         for (int s = 0; s < NS; s++) begin
            if ((dv && int'(dt) == s) || (sv && !sx && int'(st) == s)) continue;
            had = m_p0[s] | m_p1[s];
            if (m_p0[s] && m_s0[s] == int'(cr)) m_p0[s] = 0;
            if (m_p1[s] && m_s1[s] == int'(cr)) m_p1[s] = 0;
            if (had && !(m_p0[s] | m_p1[s])) begin exp_wake[s] = 1; m_busy[s] = 0; end
         end
      if (dv) begin
         m_p0[dt] = pa; m_p1[dt] = pb; m_s0[dt] = int'(s0); m_s1[dt] = int'(s1);
         m_busy[dt] = pa | pb;
         if (!(pa | pb)) exp_wake[dt] = 1;
      end
      if (ctrk) m_rdy[cr] = 1;
      if (dv && dstv && int'(dst) < NP) m_rdy[dst] = 0;
   endtask

   task automatic check(string req);
      checks++;
      if (wake_vec !== exp_wake) begin
         fails++;
         $display("FAIL %s wake_vec act=%h exp=%h", req, wake_vec, exp_wake);
      end
      checks++;
      if (reg_ready !== rdy_vec()) begin
         fails++;
         $display("FAIL %s reg_ready act=%h exp=%h", req, reg_ready, rdy_vec());
      end
   endtask

   task automatic idle_inputs();
      dv = 0; dstv = 0; s0v = 0; s1v = 0; cv = 0; sv = 0; sx = 0;
   endtask

   task automatic cycle(string req);
      model_step();
      @(posedge clk);
      @(negedge clk);
      check(req);
      idle_inputs();
   endtask

   task automatic disp(int tag, bit dvl, int d, bit av, int a, bit bv, int b);
      dv = 1; dt = TW'(tag); dstv = dvl; dst = RW'(d);
      s0v = av; s0 = RW'(a); s1v = bv; s1 = RW'(b);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < NP; i++) m_rdy[i] = 1;
      for (int s = 0; s < NS; s++) begin m_p0[s] = 0; m_p1[s] = 0; m_busy[s] = 0; m_s0[s] = 0; m_s1[s] = 0; end
      exp_wake = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      check("R1");

      disp(0, 1, 3, 0, 0, 0, 0);            cycle("R2_R4");
      disp(1, 1, 28, 1, 3, 1, 30);          cycle("R3");
      disp(2, 1, 4, 1, 3, 1, 3);            cycle("R6");
      disp(3, 1, 5, 1, 3, 0, 0);            cycle("R5");
      sv = 1; st = 3; sx = 0;               cycle("R8");
      disp(4, 1, 6, 1, 3, 0, 0);            cycle("R9");
      sv = 1; st = 4; sx = 1;               cycle("R9");
      cv = 1; cr = 3;                       cycle("R5_R6_R8_R9_R11");
      disp(5, 0, 0, 1, 4, 0, 0); cv = 1; cr = 4; cycle("R7");
      disp(6, 1, 5, 0, 0, 0, 0); cv = 1; cr = 5; cycle("R12");
      cv = 1; cr = 5;                       cycle("R5");

      for (int n = 0; n < 4000; n++) begin
         int free_tag, d, a, b;
         free_tag = -1;
         for (int s = 0; s < NS; s++) if (!m_busy[s] && free_tag < 0 && ($urandom % 3 != 0)) free_tag = s;
         if (free_tag >= 0 && ($urandom % 2 == 0)) begin
            d = $urandom % 32; a = $urandom % 32; b = $urandom % 32;
            if (d < NP && waits_on(d)) d = 31;
            disp(free_tag, $urandom % 4 != 0, d, $urandom % 4 != 0, a, $urandom % 2 == 0, b);
         end
         if ($urandom % 3 == 0) begin cv = 1; cr = RW'($urandom % 28); end
         if ($urandom % 8 == 0) begin
            int t = $urandom % NS;
            if (m_busy[t] && !(dv && int'(dt) == t)) begin sv = 1; st = TW'(t); sx = ($urandom % 3 == 0); end
         end
         if (cv && dv && dstv && dst == cr && int'(dst) < NP && waits_on(int'(dst))) dstv = 0;
         cycle("R5");
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule